// File: doc/BRIEF.md
# Out-of-Order-Completion Integer Divider with Destination Scoreboard

This unit sits next to a simple in-order pipeline and takes over 32-bit integer division so that the pipeline does not wait on it. When the pipeline hands it a quotient or remainder operation, it receives both operand values and a destination register index. The pipeline then keeps issuing the instructions that follow. Inside the unit, a radix-2 restoring iteration produces one quotient bit per clock. A final cycle corrects the signs and applies the special-case results. The finished value is offered on a valid/ready writeback port, tagged with the destination index that the originating instruction named.

The unit keeps track of the single destination that is still waiting for its value. The pipeline shows it each younger instruction's source and destination indices. If a younger instruction reads the pending register, the unit holds the pipeline with `stall` until the register file has accepted the divider's result. If a younger instruction writes the pending register and is not held, its value makes the division's result obsolete. The unit then drops the work quietly, and its result is never written back. Only one division can be in flight at a time. Register index zero is hard-wired, so a division aimed at it is discarded.

Top module: `nb_divider`

## Requirements
- R1: Operation code `issue_op` selects 2'b00 signed quotient, 2'b01 unsigned quotient, 2'b10 signed remainder, 2'b11 unsigned remainder. Signed quotients truncate toward zero, and a signed remainder carries the dividend's sign.
- R2: A zero divisor gives a quotient of all ones and a remainder equal to the dividend, for both the signed and the unsigned forms.
- R3: Dividing the most negative signed value by -1 gives that dividend as quotient and zero as remainder.
- R4: After the rising edge that accepts an issue, `wb_valid` is first seen high after the 33rd rising edge, with `wb_rd` equal to the issued destination.
- R5: While a division is in flight, younger instructions whose source and destination indices differ from the pending one see `stall` low.
- R6: While a destination is pending, a younger read of it on either source port (`rs1_en`/`rs1` or `rs2_en`/`rs2`) holds `stall` high. This continues up to and including the cycle in which the writeback is accepted, and `stall` drops in the following cycle.
- R7: A younger write (`wr_en`, `wr_rd`) to the pending destination that is not stalled cancels the division. No writeback follows, and a new issue is accepted at once without stall.
- R8: A cancelling write that arrives in the very cycle the division completes wins, and no writeback is ever offered.
- R9: While `wb_valid` is high and `wb_ready` is low, `wb_valid`, `wb_data` and `wb_rd` hold steady, and reads of the pending destination keep stalling.
- R10: Issuing while a division is pending raises `stall` and is not accepted. The held issue is accepted in the cycle the previous result's writeback completes.
- R11: An issue with destination index 0 creates no pending entry, raises no stall even while the unit is busy, and produces no writeback.
- R12: During and right after reset, `stall` and `wb_valid` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| issue_valid | input | 1 | A divide or remainder is being issued |
| issue_op | input | 2 | Operation code (see R1) |
| issue_rd | input | 5 | Destination register index of the issued operation |
| issue_a | input | 32 | Dividend |
| issue_b | input | 32 | Divisor |
| rs1_en | input | 1 | Younger instruction reads its first source |
| rs1 | input | 5 | First source index of the younger instruction |
| rs2_en | input | 1 | Younger instruction reads its second source |
| rs2 | input | 5 | Second source index of the younger instruction |
| wr_en | input | 1 | Younger instruction writes a destination |
| wr_rd | input | 5 | Destination index of the younger instruction |
| stall | output | 1 | Hold the pipeline stage |
| wb_valid | output | 1 | Writeback request |
| wb_ready | input | 1 | Register file accepts the writeback |
| wb_rd | output | 5 | Writeback destination index |
| wb_data | output | 32 | Writeback value |

## Verification
The bench builds the unit with its default parameters: a 32-bit data width and 5-bit register indices. At that width the bench can reach the most-negative-by-minus-one case and all-ones divisors. Full-range unsigned operands exercise the partial remainder's extra top bit. The 33-cycle latency is also short enough that a cancel can be placed exactly in the sign-correction cycle, and that the cycle where one result's writeback meets the next issue can be hit on purpose.

// File: rtl/div_pkg.sv
package div_pkg;

  typedef enum logic [1:0] {
    OP_DIV  = 2'b00,
    OP_DIVU = 2'b01,
    OP_REM  = 2'b10,
    OP_REMU = 2'b11
  } div_op_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'b00,
    ST_RUN  = 2'b01,
    ST_FIX  = 2'b10
  } div_state_e;

  function automatic logic op_is_signed(input div_op_e op);
    return ~op[0];
  endfunction

  function automatic logic op_wants_rem(input div_op_e op);
    return op[1];
  endfunction

endpackage

// File: rtl/div_iter.sv
module div_iter
  import div_pkg::*;
#(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic         abort,
  input  div_op_e      op,
  input  logic [W-1:0] opa,
  input  logic [W-1:0] opb,
  output logic         done,
  output logic [W-1:0] result
);

  localparam int CW = $clog2(W + 1);
  localparam logic [CW-1:0] LAST = CW'(W - 1);

  div_state_e   st_q, st_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic [W-1:0] rem_q, rem_d;
  logic [W-1:0] quo_q, quo_d;
  logic [W-1:0] dvs_q, dvs_d;
  logic [W-1:0] dvd_q, dvd_d;
  logic         negq_q, negq_d;
  logic         negr_q, negr_d;
  logic         zero_q, zero_d;
  logic         wrem_q, wrem_d;

  logic         sgn;
  logic [W-1:0] mag_a, mag_b;
  logic [W:0]   shifted, trial;
  logic [W-1:0] fix_q, fix_r;

  always_comb begin
    sgn     = op_is_signed(op);
    mag_a   = (sgn && opa[W-1]) ? (~opa + 1'b1) : opa;
    mag_b   = (sgn && opb[W-1]) ? (~opb + 1'b1) : opb;
    shifted = {rem_q, quo_q[W-1]};
    trial   = shifted - {1'b0, dvs_q};
  end

  always_comb begin
    st_d   = st_q;
    cnt_d  = cnt_q;
    rem_d  = rem_q;
    quo_d  = quo_q;
    dvs_d  = dvs_q;
    dvd_d  = dvd_q;
    negq_d = negq_q;
    negr_d = negr_q;
    zero_d = zero_q;
    wrem_d = wrem_q;
    if (start) begin
      st_d   = ST_RUN;
      cnt_d  = '0;
      rem_d  = '0;
      quo_d  = mag_a;
      dvs_d  = mag_b;
      dvd_d  = opa;
      negq_d = sgn & (opa[W-1] ^ opb[W-1]);
      negr_d = sgn & opa[W-1];
      zero_d = (opb == '0);
      wrem_d = op_wants_rem(op);
    end else if (abort) begin
      st_d = ST_IDLE;
    end else begin
      unique case (st_q)
        ST_RUN: begin
          if (!trial[W]) begin
            rem_d = trial[W-1:0];
            quo_d = {quo_q[W-2:0], 1'b1};
          end else begin
            rem_d = shifted[W-1:0];
            quo_d = {quo_q[W-2:0], 1'b0};
          end
          cnt_d = cnt_q + 1'b1;
          if (cnt_q == LAST) st_d = ST_FIX;
        end
        ST_FIX:  st_d = ST_IDLE;
        default: st_d = ST_IDLE;
      endcase
    end
  end

  always_comb begin
    fix_q = negq_q ? (~quo_q + 1'b1) : quo_q;
    fix_r = negr_q ? (~rem_q + 1'b1) : rem_q;
    if (zero_q) begin
      fix_q = '1;
      fix_r = dvd_q;
    end
    result = wrem_q ? fix_r : fix_q;
    done   = (st_q == ST_FIX);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_IDLE;
      cnt_q <= '0;
    end else begin
      st_q  <= st_d;
      cnt_q <= cnt_d;
    end
  end

  logic dp_en;
  assign dp_en = start | (st_q == ST_RUN);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rem_q  <= '0;
      quo_q  <= '0;
      dvs_q  <= '0;
      dvd_q  <= '0;
      negq_q <= 1'b0;
      negr_q <= 1'b0;
      zero_q <= 1'b0;
      wrem_q <= 1'b0;
    end else if (dp_en) begin
      rem_q  <= rem_d;
      quo_q  <= quo_d;
      dvs_q  <= dvs_d;
      dvd_q  <= dvd_d;
      negq_q <= negq_d;
      negr_q <= negr_d;
      zero_q <= zero_d;
      wrem_q <= wrem_d;
    end
  end

endmodule

// File: rtl/div_track.sv
module div_track #(
  parameter int RW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          issue_valid,
  input  logic [RW-1:0] issue_rd,
  input  logic          rs1_en,
  input  logic [RW-1:0] rs1,
  input  logic          rs2_en,
  input  logic [RW-1:0] rs2,
  input  logic          wr_en,
  input  logic [RW-1:0] wr_rd,
  input  logic          wb_fire,
  output logic          accept,
  output logic          cancel,
  output logic          stall,
  output logic          pending,
  output logic [RW-1:0] pend_rd
);

  logic          pend_q, pend_d;
  logic [RW-1:0] rd_q;
  logic          rd_hit, free, live;

  always_comb begin
    rd_hit = pend_q & ((rs1_en & (rs1 == rd_q)) | (rs2_en & (rs2 == rd_q)));
    free   = ~pend_q | wb_fire;
    live   = issue_valid & (issue_rd != '0);
    accept = live & free;
    cancel = pend_q & wr_en & ~rd_hit & (wr_rd == rd_q);
    stall  = rd_hit | (live & ~free);
    pend_d = pend_q;
    if (accept)                  pend_d = 1'b1;
    else if (cancel || wb_fire)  pend_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_q <= 1'b0;
    else        pend_q <= pend_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      rd_q <= '0;
    else if (accept) rd_q <= issue_rd;
  end

  assign pending = pend_q;
  assign pend_rd = rd_q;

endmodule

// File: rtl/div_wb.sv
module div_wb #(
  parameter int W  = 32,
  parameter int RW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          done,
  input  logic [W-1:0]  result,
  input  logic [RW-1:0] pend_rd,
  input  logic          cancel,
  input  logic          wb_ready,
  output logic          wb_valid,
  output logic [W-1:0]  wb_data,
  output logic [RW-1:0] wb_rd,
  output logic          wb_fire
);

  logic          vld_q, vld_d;
  logic [W-1:0]  data_q;
  logic [RW-1:0] rd_q;
  logic          load;

  always_comb begin
    wb_valid = vld_q & ~cancel;
    wb_fire  = wb_valid & wb_ready;
    load     = done & ~cancel;
    vld_d    = vld_q;
    if (load)                  vld_d = 1'b1;
    else if (wb_fire || cancel) vld_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vld_q <= 1'b0;
    else        vld_q <= vld_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q <= '0;
      rd_q   <= '0;
    end else if (load) begin
      data_q <= result;
      rd_q   <= pend_rd;
    end
  end

  assign wb_data = data_q;
  assign wb_rd   = rd_q;

endmodule

// File: rtl/nb_divider.sv
module nb_divider
  import div_pkg::*;
#(
  parameter int W  = 32,
  parameter int RW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          issue_valid,
  input  logic [1:0]    issue_op,
  input  logic [RW-1:0] issue_rd,
  input  logic [W-1:0]  issue_a,
  input  logic [W-1:0]  issue_b,
  input  logic          rs1_en,
  input  logic [RW-1:0] rs1,
  input  logic          rs2_en,
  input  logic [RW-1:0] rs2,
  input  logic          wr_en,
  input  logic [RW-1:0] wr_rd,
  output logic          stall,
  output logic          wb_valid,
  input  logic          wb_ready,
  output logic [RW-1:0] wb_rd,
  output logic [W-1:0]  wb_data
);

  logic          accept, cancel, pending, wb_fire, done;
  logic [RW-1:0] pend_rd;
  logic [W-1:0]  result;

  div_track #(.RW(RW)) u_track (
    .clk, .rst_n, .issue_valid, .issue_rd,
    .rs1_en, .rs1, .rs2_en, .rs2, .wr_en, .wr_rd,
    .wb_fire, .accept, .cancel, .stall, .pending, .pend_rd
  );

  div_iter #(.W(W)) u_iter (
    .clk, .rst_n,
    .start (accept),
    .abort (cancel),
    .op    (div_op_e'(issue_op)),
    .opa   (issue_a),
    .opb   (issue_b),
    .done,
    .result
  );

  div_wb #(.W(W), .RW(RW)) u_wb (
    .clk, .rst_n, .done, .result, .pend_rd, .cancel,
    .wb_ready, .wb_valid, .wb_data, .wb_rd, .wb_fire
  );

endmodule

// File: rtl/nb_divider_chk.sv
module nb_divider_chk #(
  parameter int W  = 32,
  parameter int RW = 5
) (
  input logic          clk,
  input logic          rst_n,
  input logic          issue_valid,
  input logic [RW-1:0] issue_rd,
  input logic          rs1_en,
  input logic [RW-1:0] rs1,
  input logic          rs2_en,
  input logic [RW-1:0] rs2,
  input logic          stall,
  input logic          wb_valid,
  input logic          wb_ready,
  input logic [RW-1:0] wb_rd,
  input logic [W-1:0]  wb_data,
  input logic          pending,
  input logic [RW-1:0] pend_rd,
  input logic          cancel
);

  a_r6_read1_stalls: assert property (@(posedge clk) disable iff (!rst_n)
    (pending && rs1_en && rs1 == pend_rd) |-> stall);

  a_r6_read2_stalls: assert property (@(posedge clk) disable iff (!rst_n)
    (pending && rs2_en && rs2 == pend_rd) |-> stall);

  a_r7_cancel_frees: assert property (@(posedge clk) disable iff (!rst_n)
    cancel |=> !wb_valid);

  a_r8_cancel_wins: assert property (@(posedge clk) disable iff (!rst_n)
    cancel |-> !wb_valid);

  a_r9_hold_result: assert property (@(posedge clk) disable iff (!rst_n)
    (wb_valid && !wb_ready) |=> ($stable(wb_data) && $stable(wb_rd) && pending));

  a_r10_single_flight: assert property (@(posedge clk) disable iff (!rst_n)
    (pending && issue_valid && issue_rd != '0 && !(wb_valid && wb_ready)) |-> stall);

  a_r11_no_x0_write: assert property (@(posedge clk) disable iff (!rst_n)
    wb_valid |-> (wb_rd != '0 && pending && wb_rd == pend_rd));

  a_r11_x0_no_entry: assert property (@(posedge clk) disable iff (!rst_n)
    (issue_valid && issue_rd == '0 && !pending) |=> !pending);

endmodule

bind nb_divider nb_divider_chk #(.W(W), .RW(RW)) u_chk (
  .clk, .rst_n, .issue_valid, .issue_rd, .rs1_en, .rs1, .rs2_en, .rs2,
  .stall, .wb_valid, .wb_ready, .wb_rd, .wb_data, .pending, .pend_rd, .cancel
);

// File: tb/nb_divider_test.sv
module nb_divider_test;

  localparam int W  = 32;
  localparam int RW = 5;
  localparam logic [W-1:0] MINV = {1'b1, {(W-1){1'b0}}};

  logic          clk, rst_n;
  logic          issue_valid;
  logic [1:0]    issue_op;
  logic [RW-1:0] issue_rd;
  logic [W-1:0]  issue_a, issue_b;
  logic          rs1_en, rs2_en, wr_en, wb_ready;
  logic [RW-1:0] rs1, rs2, wr_rd;
  logic          stall, wb_valid;
  logic [RW-1:0] wb_rd;
  logic [W-1:0]  wb_data;

  int tests = 0;
  int fails = 0;
  logic last_stall;

  nb_divider #(.W(W), .RW(RW)) uut (
    .clk, .rst_n, .issue_valid, .issue_op, .issue_rd, .issue_a, .issue_b,
    .rs1_en, .rs1, .rs2_en, .rs2, .wr_en, .wr_rd,
    .stall, .wb_valid, .wb_ready, .wb_rd, .wb_data
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  function automatic logic [W-1:0] model(input logic [1:0] op, input logic [W-1:0] a, input logic [W-1:0] b);
    logic ovf;
    ovf = (a == MINV) && (b == '1);
    case (op)
      2'b00:   model = (b == '0) ? '1 : ovf ? a : W'($signed(a) / $signed(b));
      2'b01:   model = (b == '0) ? '1 : a / b;
      2'b10:   model = (b == '0) ? a : ovf ? '0 : W'($signed(a) % $signed(b));
      default: model = (b == '0) ? a : a % b;
    endcase
  endfunction

  task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic do_issue(input logic [1:0] op, input logic [RW-1:0] rd, input logic [W-1:0] a, input logic [W-1:0] b);
    issue_valid = 1'b1;
    issue_op    = op;
    issue_rd    = rd;
    issue_a     = a;
    issue_b     = b;
    #1 last_stall = stall;
    @(posedge clk);
    #1 issue_valid = 1'b0;
  endtask

  task automatic wait_result(input string req, input logic [RW-1:0] rd, input logic [W-1:0] exp, input int lat);
    int n;
    n = 0;
    for (int i = 0; i < 60; i++) begin
      tick();
      n++;
      if (wb_valid) break;
    end
    chk(req, W'(wb_valid), W'(1));
    chk(req, W'(wb_rd), W'(rd));
    chk(req, wb_data, exp);
    if (lat > 0) chk("R4 latency", W'(n), W'(lat));
    tick();
  endtask

  task automatic run_op(input string req, input logic [1:0] op, input logic [W-1:0] a, input logic [W-1:0] b);
    do_issue(op, 5'd3, a, b);
    wait_result(req, 5'd3, model(op, a, b), 33);
  endtask

  task automatic t_reset();
    chk("R12 stall", W'(stall), W'(0));
    chk("R12 wb_valid", W'(wb_valid), W'(0));
  endtask

  task automatic t_ops();
    run_op("R1 div", 2'b00, 32'hFFFF_FF9C, 32'd7);
    run_op("R1 divu", 2'b01, 32'hFFFF_FF9C, 32'd7);
    run_op("R1 rem", 2'b10, 32'hFFFF_FF9C, 32'd7);
    run_op("R1 remu", 2'b11, 32'hFFFF_FF9C, 32'd7);
    run_op("R1 div negdivisor", 2'b00, 32'd1000, 32'hFFFF_FFFD);
    run_op("R1 rem negdivisor", 2'b10, 32'd1000, 32'hFFFF_FFFD);
    run_op("R1 divu big", 2'b01, 32'hFFFF_FFFF, 32'h8000_0001);
    run_op("R1 remu big", 2'b11, 32'hFFFF_FFFF, 32'hFFFF_FFFE);
  endtask

  task automatic t_corner();
    run_op("R2 div zero", 2'b00, 32'hFFFF_FFF0, 32'd0);
    run_op("R2 divu zero", 2'b01, 32'd77, 32'd0);
    run_op("R2 rem zero", 2'b10, 32'hFFFF_FFF0, 32'd0);
    run_op("R2 remu zero", 2'b11, 32'd77, 32'd0);
    run_op("R3 div overflow", 2'b00, MINV, '1);
    run_op("R3 rem overflow", 2'b10, MINV, '1);
  endtask

  task automatic t_nonblock();
    int bad;
    bad = 0;
    do_issue(2'b00, 5'd6, 32'd500, 32'd9);
    rs1_en = 1'b1; rs1 = 5'd1; rs2_en = 1'b1; rs2 = 5'd2; wr_en = 1'b1; wr_rd = 5'd8;
    for (int i = 0; i < 10; i++) begin
      #1 if (stall) bad++;
      tick();
    end
    rs1_en = 1'b0; rs2_en = 1'b0; wr_en = 1'b0;
    chk("R5 independent no stall", W'(bad), W'(0));
    wait_result("R5 result", 5'd6, model(2'b00, 32'd500, 32'd9), 0);
  endtask

  task automatic t_raw();
    int miss;
    miss = 0;
    do_issue(2'b11, 5'd7, 32'd12345, 32'd100);
    rs2_en = 1'b1; rs2 = 5'd7;
    #1 chk("R6 read stalls", W'(stall), W'(1));
    for (int i = 0; i < 60; i++) begin
      tick();
      if (wb_valid) break;
      if (!stall) miss++;
    end
    chk("R6 stall held", W'(miss), W'(0));
    chk("R6 stall at accept", W'(stall), W'(1));
    chk("R6 data", wb_data, model(2'b11, 32'd12345, 32'd100));
    tick();
    chk("R6 released", W'(stall), W'(0));
    rs2_en = 1'b0;
  endtask

  task automatic t_cancel();
    int seen;
    seen = 0;
    do_issue(2'b00, 5'd9, 32'd999, 32'd3);
    repeat (5) tick();
    wr_en = 1'b1; wr_rd = 5'd9;
    tick();
    wr_en = 1'b0;
    for (int i = 0; i < 40; i++) begin
      if (wb_valid) seen++;
      tick();
    end
    chk("R7 no writeback", W'(seen), W'(0));
    do_issue(2'b01, 5'd10, 32'd81, 32'd9);
    chk("R7 freed", W'(last_stall), W'(0));
    wait_result("R7 next result", 5'd10, 32'd9, 33);
  endtask

  task automatic t_cancel_complete();
    int seen;
    seen = 0;
    do_issue(2'b00, 5'd11, 32'd64, 32'd4);
    repeat (32) tick();
    wr_en = 1'b1; wr_rd = 5'd11;
    #1 chk("R8 no valid in final cycle", W'(wb_valid), W'(0));
    tick();
    wr_en = 1'b0;
    for (int i = 0; i < 6; i++) begin
      if (wb_valid) seen++;
      tick();
    end
    chk("R8 younger write wins", W'(seen), W'(0));
  endtask

  task automatic t_hold();
    logic [W-1:0] d;
    wb_ready = 1'b0;
    do_issue(2'b10, 5'd12, 32'hFFFF_FC18, 32'd7);
    for (int i = 0; i < 60; i++) begin
      tick();
      if (wb_valid) break;
    end
    d = wb_data;
    chk("R9 data", d, model(2'b10, 32'hFFFF_FC18, 32'd7));
    rs1_en = 1'b1; rs1 = 5'd12;
    for (int i = 0; i < 4; i++) begin
      tick();
      chk("R9 valid held", W'(wb_valid), W'(1));
      chk("R9 data held", wb_data, d);
      chk("R9 stall held", W'(stall), W'(1));
    end
    wb_ready = 1'b1;
    tick();
    chk("R9 released valid", W'(wb_valid), W'(0));
    chk("R9 released stall", W'(stall), W'(0));
    rs1_en = 1'b0;
  endtask

  task automatic t_busy();
    int miss;
    miss = 0;
    do_issue(2'b01, 5'd3, 32'd100, 32'd10);
    issue_valid = 1'b1; issue_op = 2'b01; issue_rd = 5'd4; issue_a = 32'd300; issue_b = 32'd7;
    #1 chk("R10 busy stalls", W'(stall), W'(1));
    for (int i = 0; i < 60; i++) begin
      tick();
      if (wb_valid) break;
      if (!stall) miss++;
    end
    chk("R10 stall held", W'(miss), W'(0));
    chk("R10 first data", wb_data, 32'd10);
    chk("R10 accept at writeback", W'(stall), W'(0));
    @(posedge clk);
    #1 issue_valid = 1'b0;
    wait_result("R10 second", 5'd4, 32'd42, 33);
  endtask

  task automatic t_x0();
    int seen;
    seen = 0;
    do_issue(2'b01, 5'd5, 32'd90, 32'd9);
    issue_valid = 1'b1; issue_rd = 5'd0; issue_a = 32'd1; issue_b = 32'd1;
    #1 chk("R11 x0 no stall while busy", W'(stall), W'(0));
    tick();
    issue_valid = 1'b0;
    wait_result("R11 real result", 5'd5, 32'd10, 0);
    do_issue(2'b00, 5'd0, 32'd50, 32'd5);
    for (int i = 0; i < 40; i++) begin
      if (wb_valid) seen++;
      tick();
    end
    chk("R11 x0 no writeback", W'(seen), W'(0));
    do_issue(2'b00, 5'd13, 32'd50, 32'd5);
    chk("R11 no entry left", W'(last_stall), W'(0));
    wait_result("R11 after x0", 5'd13, 32'd10, 33);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    tests++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    issue_valid = 1'b0; issue_op = '0; issue_rd = '0; issue_a = '0; issue_b = '0;
    rs1_en = 1'b0; rs1 = '0; rs2_en = 1'b0; rs2 = '0; wr_en = 1'b0; wr_rd = '0;
    wb_ready = 1'b1;
    last_stall = 1'b0;
    #2 t_reset();
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    tick();
    t_reset();
    t_ops();
    t_corner();
    t_nonblock();
    t_raw();
    t_cancel();
    t_cancel_complete();
    t_hold();
    t_busy();
    t_x0();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule